// File: doc/BRIEF.md
# Banked Stack Pointer Unit

This block keeps two stack pointers for a processor core. The main pointer serves reset, exceptions and interrupts. The thread pointer serves ordinary code once software has moved into thread context. The unit tracks handler nesting and decides which pointer is active. For every push or pop it returns the effective byte address and updates the active pointer. Each push is compared against a lower-limit register that belongs to the same stack. A push that would go below that limit is blocked.

The stack grows downward in 4-byte words. A push pre-decrements the pointer and a pop post-increments it. Software reaches both pointers, both limits and a status word through a small indexed register port. A normal push that overflows raises a one-cycle exception output. A push made as part of hardware frame saving on exception entry does not raise that exception, because doing so would start a recursive check loop. It sets a sticky status bit instead.

Top module: `stkptr_bank`

## Requirements
- R1: After reset the main pointer is active (`sp_sel` = 0), registers 0 to 4 all read zero, and `ovf_exc` is low.
- R2: Writes to index 0 (main pointer), 1 (thread pointer), 2 (main limit) and 3 (thread limit) store the value with its two low bits cleared, and reads of the same index return that value. Reads are combinational.
- R3: A push presents `sp_addr` = active pointer − 4 in the same cycle and stores that value into the active pointer. A pop presents the current pointer and stores pointer + 4. When both strobes are high, the push wins. When no strobe is high, `sp_addr` shows the active pointer.
- R4: A push whose new address is strictly below the active stack's limit, compared as unsigned numbers, drives `ovf_exc` high in that cycle and leaves the pointer unchanged. An address equal to the limit is allowed. A limit of zero never triggers.
- R5: While no exception is being handled, `sp_sel` follows `thread_mode` one cycle later. With `sp_sel` = 1, pushes and pops use the thread pointer and the thread limit.
- R6: The cycle after an `exc_entry` strobe, the main pointer is active, whichever pointer was active before.
- R7: Nested entries keep the main pointer active. The exit that ends the outermost handler restores the selection that was saved at the first entry. Status bits [4:2] report the nesting depth.
- R8: A push with `push_frame` high that would overflow is blocked and leaves `ovf_exc` low. It sets the sticky status bit 0.
- R9: Writing index 4 with data bit 0 set clears the sticky bit. Writing index 4 with bit 0 clear leaves it set.
- R10: An `exc_exit` strobe while no handler is active has no effect on depth or selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_idx | input | 3 | Register index: 0 main SP, 1 thread SP, 2 main limit, 3 thread limit, 4 status |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data for `reg_idx` |
| thread_mode | input | 1 | Software request to run on the thread stack |
| exc_entry | input | 1 | Exception/interrupt entry strobe |
| exc_exit | input | 1 | Exception/interrupt return strobe |
| push | input | 1 | Push one word |
| pop | input | 1 | Pop one word |
| push_frame | input | 1 | Marks a push as part of exception frame saving |
| sp_addr | output | AW | Effective address of the current access |
| sp_sel | output | 1 | Active stack: 0 main, 1 thread |
| ovf_exc | output | 1 | Stack-overflow exception, one cycle |

## Verification
Several checks run on every cycle. They confirm that pointers stay word aligned and that a blocked push leaves its pointer untouched. They also confirm that the main stack is active during any handler, that an entry selects it, that a stray exit leaves the depth alone, and how the sticky bit is set and cleared. Some behaviours need whole scenarios and can only be shown by the bench. These are the address arithmetic across the limit boundary, the unsigned wrap near address zero, the thread/handler sequence with nested entries, and the readback of every register after masked writes.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

    localparam int WORD_BYTES = 4;
    localparam int NBANK      = 2;

    typedef enum logic {
        BANK_MAIN   = 1'b0,
        BANK_THREAD = 1'b1
    } bank_e;

    typedef enum logic [2:0] {
        RI_MSP  = 3'd0,
        RI_TSP  = 3'd1,
        RI_MLIM = 3'd2,
        RI_TLIM = 3'd3,
        RI_STAT = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic frame;
    } stk_op_t;

    function automatic logic [2:0] sp_index(input int b);
        return (b == 0) ? RI_MSP : RI_TSP;
    endfunction

    function automatic logic [2:0] lim_index(input int b);
        return (b == 0) ? RI_MLIM : RI_TLIM;
    endfunction

endpackage

// File: rtl/stkptr_chk.sv
module stkptr_chk
    import stkptr_pkg::*;
#(
    parameter int AW   = 32,
    parameter int STEP = WORD_BYTES
) (
    input  stk_op_t       op,
    input  logic [AW-1:0] sp,
    input  logic [AW-1:0] lim,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] next,
    output logic          hit,
    output logic          upd
);
    localparam logic [AW-1:0] STEP_V = AW'(STEP);

    logic [AW-1:0] dec_v;
    logic [AW-1:0] inc_v;

    always_comb begin
        dec_v = sp - STEP_V;
        inc_v = sp + STEP_V;
        hit   = op.push && (dec_v < lim);
        addr  = op.push ? dec_v : sp;
        next  = op.push ? dec_v : inc_v;
        upd   = (op.push && !hit) || (op.pop && !op.push);
    end

endmodule

// File: rtl/stkptr_ctx.sv
module stkptr_ctx
    import stkptr_pkg::*;
#(
    parameter int MAX_NEST = 7,
    localparam int DEPTH_W = $clog2(MAX_NEST + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               thread_mode,
    input  logic               exc_entry,
    input  logic               exc_exit,
    output bank_e              bank,
    output logic [DEPTH_W-1:0] depth
);
    localparam logic [DEPTH_W-1:0] DMAX = DEPTH_W'(MAX_NEST);
    localparam logic [DEPTH_W-1:0] ONE  = DEPTH_W'(1);

    bank_e cur_q;
    bank_e saved_q;
    logic [DEPTH_W-1:0] depth_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= BANK_MAIN;
            saved_q <= BANK_MAIN;
            depth_q <= '0;
        end else if (exc_entry) begin
            if (depth_q != DMAX) depth_q <= depth_q + ONE;
            if (depth_q == '0)   saved_q <= cur_q;
            cur_q <= BANK_MAIN;
        end else if (exc_exit && depth_q != '0) begin
            depth_q <= depth_q - ONE;
            if (depth_q == ONE) cur_q <= saved_q;
        end else if (depth_q == '0) begin
            cur_q <= thread_mode ? BANK_THREAD : BANK_MAIN;
        end
    end

    assign bank  = cur_q;
    assign depth = depth_q;

    p_entry_main_r6: assert property (@(posedge clk) disable iff (rst)
        exc_entry |=> bank == BANK_MAIN);

    p_nest_main_r7: assert property (@(posedge clk) disable iff (rst)
        depth != '0 |-> bank == BANK_MAIN);

    p_restore_r7: assert property (@(posedge clk) disable iff (rst)
        (exc_exit && !exc_entry && depth == ONE) |=> bank == $past(saved_q));

    p_exit_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (exc_exit && !exc_entry && depth == '0) |=> depth == '0);

endmodule

// File: rtl/stkptr_file.sv
module stkptr_file
    import stkptr_pkg::*;
#(
    parameter int AW      = 32,
    parameter int ALIGN_W = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      we,
    input  logic [2:0]                widx,
    input  logic [AW-1:0]             wdata,
    input  bank_e                     sel,
    input  logic                      upd,
    input  logic                      blk,
    input  logic [AW-1:0]             next,
    output logic [NBANK-1:0][AW-1:0]  sp_q,
    output logic [NBANK-1:0][AW-1:0]  lim_q
);
    localparam logic [AW-1:0] MASK = ~AW'((1 << ALIGN_W) - 1);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic [2:0] SP_I  = sp_index(b);
        localparam logic [2:0] LIM_I = lim_index(b);

        logic mine;
        assign mine = (sel == bank_e'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                sp_q[b] <= '0;
            end else if (upd && mine) begin
                sp_q[b] <= next;
            end else if (we && widx == SP_I) begin
                sp_q[b] <= wdata & MASK;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lim_q[b] <= '0;
            end else if (we && widx == LIM_I) begin
                lim_q[b] <= wdata & MASK;
            end
        end

        p_align_r2: assert property (@(posedge clk) disable iff (rst)
            sp_q[b][ALIGN_W-1:0] == '0 && lim_q[b][ALIGN_W-1:0] == '0);

        p_block_hold_r4: assert property (@(posedge clk) disable iff (rst)
            (blk && mine && !(we && widx == SP_I)) |=> $stable(sp_q[b]));
    end

endmodule

// File: rtl/stkptr_bank.sv
module stkptr_bank
    import stkptr_pkg::*;
#(
    parameter int AW       = 32,
    parameter int MAX_NEST = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_idx,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    input  logic          thread_mode,
    input  logic          exc_entry,
    input  logic          exc_exit,
    input  logic          push,
    input  logic          pop,
    input  logic          push_frame,
    output logic [AW-1:0] sp_addr,
    output logic          sp_sel,
    output logic          ovf_exc
);
    localparam int ALIGN_W = $clog2(WORD_BYTES);
    localparam int DEPTH_W = $clog2(MAX_NEST + 1);

    stk_op_t                  op;
    bank_e                    bank;
    logic [DEPTH_W-1:0]       depth;
    logic [NBANK-1:0][AW-1:0] sp_q;
    logic [NBANK-1:0][AW-1:0] lim_q;
    logic [AW-1:0]            next;
    logic                     hit;
    logic                     upd;
    logic                     sticky_q;

    assign op = '{push: push, pop: pop, frame: push_frame};

    stkptr_ctx #(.MAX_NEST(MAX_NEST)) u_ctx (
        .clk(clk), .rst(rst), .thread_mode(thread_mode),
        .exc_entry(exc_entry), .exc_exit(exc_exit),
        .bank(bank), .depth(depth)
    );

    stkptr_chk #(.AW(AW), .STEP(WORD_BYTES)) u_chk (
        .op(op), .sp(sp_q[bank]), .lim(lim_q[bank]),
        .addr(sp_addr), .next(next), .hit(hit), .upd(upd)
    );

    stkptr_file #(.AW(AW), .ALIGN_W(ALIGN_W)) u_file (
        .clk(clk), .rst(rst), .we(reg_we), .widx(reg_idx), .wdata(reg_wdata),
        .sel(bank), .upd(upd), .blk(hit), .next(next),
        .sp_q(sp_q), .lim_q(lim_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sticky_q <= 1'b0;
        end else if (hit && op.frame) begin
            sticky_q <= 1'b1;
        end else if (reg_we && reg_idx == RI_STAT && reg_wdata[0]) begin
            sticky_q <= 1'b0;
        end
    end

    assign ovf_exc = hit && !op.frame;
    assign sp_sel  = (bank == BANK_THREAD);

    always_comb begin
        case (reg_idx)
            RI_MSP:  reg_rdata = sp_q[0];
            RI_TSP:  reg_rdata = sp_q[1];
            RI_MLIM: reg_rdata = lim_q[0];
            RI_TLIM: reg_rdata = lim_q[1];
            RI_STAT: reg_rdata = AW'({depth, sp_sel, sticky_q});
            default: reg_rdata = '0;
        endcase
    end

    p_sticky_set_r8: assert property (@(posedge clk) disable iff (rst)
        (push && push_frame && hit) |=> sticky_q);

    p_sticky_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_idx == RI_STAT && reg_wdata[0] && !(push && push_frame && hit))
        |=> !sticky_q);

    p_ovf_push_r4: assert property (@(posedge clk) disable iff (rst)
        ovf_exc |-> push);

endmodule

// File: tb/stkptr_bank_bench.sv
module stkptr_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        thread_mode = 1'b0;
    logic        exc_entry = 1'b0;
    logic        exc_exit = 1'b0;
    logic        push = 1'b0;
    logic        pop = 1'b0;
    logic        push_frame = 1'b0;
    logic [31:0] sp_addr;
    logic        sp_sel;
    logic        ovf_exc;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    stkptr_bank u_stkptr_bank (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .thread_mode(thread_mode),
        .exc_entry(exc_entry), .exc_exit(exc_exit), .push(push), .pop(pop),
        .push_frame(push_frame), .sp_addr(sp_addr), .sp_sel(sp_sel), .ovf_exc(ovf_exc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc;
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] val);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
        cyc();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] val);
        reg_idx = idx;
        #1;
        val = reg_rdata;
    endtask

    task automatic do_push(input logic frame, output logic [31:0] a, output logic o);
        push = 1'b1; push_frame = frame;
        #1;
        a = sp_addr; o = ovf_exc;
        cyc();
        push = 1'b0; push_frame = 1'b0;
    endtask

    task automatic pulse_entry;
        exc_entry = 1'b1; cyc(); exc_entry = 1'b0;
    endtask

    task automatic pulse_exit;
        exc_exit = 1'b1; cyc(); exc_exit = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] v, a, e;
        logic        o;

        repeat (3) cyc();
        rst = 1'b0;
        cyc();

        // R1 reset state
        for (int i = 0; i < 5; i++) begin
            rd(3'(i), v);
            chk($sformatf("R1 reg%0d", i), v, 32'd0);
        end
        chk("R1 sp_sel", {31'd0, sp_sel}, 32'd0);
        chk("R1 ovf_exc", {31'd0, ovf_exc}, 32'd0);

        // R2 masked writes on all four pointer/limit registers
        for (int r = 0; r < 4; r++) begin
            for (int lo = 0; lo < 4; lo++) begin
                e = 32'h1000_0000 * (r + 1) + 32'h40 * lo;
                wr(3'(r), e | 32'(lo));
                rd(3'(r), v);
                chk($sformatf("R2 reg%0d lo%0d", r, lo), v, e);
            end
        end

        // R3/R4 sweep on main stack across limit boundary, two limits
        for (int li = 0; li < 2; li++) begin
            logic [31:0] lim;
            lim = (li == 0) ? 32'd0 : 32'h100;
            wr(3'd2, lim);
            for (int k = 0; k < 8; k++) begin
                logic [31:0] sp;
                sp = 32'hF8 + 32'(4 * k);
                wr(3'd0, sp);
                e = sp - 32'd4;
                do_push(1'b0, a, o);
                chk($sformatf("R3 push addr sp=%h", sp), a, e);
                chk($sformatf("R4 ovf sp=%h lim=%h", sp, lim), {31'd0, o}, {31'd0, (e < lim)});
                rd(3'd0, v);
                chk($sformatf("R4 sp after push sp=%h", sp), v, (e < lim) ? sp : e);
                wr(3'd0, sp);
                pop = 1'b1; #1; a = sp_addr; cyc(); pop = 1'b0;
                chk($sformatf("R3 pop addr sp=%h", sp), a, sp);
                rd(3'd0, v);
                chk($sformatf("R3 sp after pop sp=%h", sp), v, sp + 32'd4);
            end
        end

        // R4 wrap near zero: not an overflow, pointer wraps
        wr(3'd0, 32'd0);
        do_push(1'b0, a, o);
        chk("R4 wrap addr", a, 32'hFFFF_FFFC);
        chk("R4 wrap no ovf", {31'd0, o}, 32'd0);

        // R3 simultaneous push and pop: push wins
        wr(3'd2, 32'd0);
        wr(3'd0, 32'h200);
        push = 1'b1; pop = 1'b1; #1; a = sp_addr; cyc(); push = 1'b0; pop = 1'b0;
        chk("R3 push wins addr", a, 32'h1FC);
        rd(3'd0, v);
        chk("R3 push wins sp", v, 32'h1FC);

        // R5 thread stack selection and its own limit
        wr(3'd1, 32'h2000);
        wr(3'd3, 32'h1FF8);
        thread_mode = 1'b1;
        #1;
        chk("R5 sel not yet", {31'd0, sp_sel}, 32'd0);
        cyc();
        chk("R5 sel thread", {31'd0, sp_sel}, 32'd1);
        chk("R5 addr thread", sp_addr, 32'h2000);
        do_push(1'b0, a, o);
        chk("R5 push1", a, 32'h1FFC);
        do_push(1'b0, a, o);
        chk("R4 equal limit allowed", {31'd0, o}, 32'd0);
        do_push(1'b0, a, o);
        chk("R4 thread ovf", {31'd0, o}, 32'd1);
        rd(3'd1, v);
        chk("R4 thread sp held", v, 32'h1FF8);
        rd(3'd0, v);
        chk("R5 main untouched", v, 32'h1FC);

        // R6 entry selects main
        pulse_entry();
        chk("R6 sel main", {31'd0, sp_sel}, 32'd0);
        chk("R6 addr main", sp_addr, 32'h1FC);

        // R7 nesting
        pulse_entry();
        rd(3'd4, v);
        chk("R7 depth2 status", v, 32'd2 << 2);
        pulse_exit();
        chk("R7 inner exit stays main", {31'd0, sp_sel}, 32'd0);
        rd(3'd4, v);
        chk("R7 depth1 status", v, 32'd1 << 2);
        pulse_exit();
        chk("R7 outer exit thread", {31'd0, sp_sel}, 32'd1);
        chk("R7 outer exit addr", sp_addr, 32'h1FF8);

        // R10 stray exit
        thread_mode = 1'b0;
        cyc();
        chk("R5 back to main", {31'd0, sp_sel}, 32'd0);
        pulse_exit();
        rd(3'd4, v);
        chk("R10 stray exit status", v, 32'd0);
        chk("R10 stray exit sel", {31'd0, sp_sel}, 32'd0);

        // R8 frame push overflow
        wr(3'd0, 32'h40);
        wr(3'd2, 32'h40);
        pulse_entry();
        do_push(1'b1, a, o);
        chk("R8 frame no ovf_exc", {31'd0, o}, 32'd0);
        rd(3'd0, v);
        chk("R8 frame push blocked", v, 32'h40);
        rd(3'd4, v);
        chk("R8 sticky set", v & 32'd1, 32'd1);

        // R9 clearing
        wr(3'd4, 32'd0);
        rd(3'd4, v);
        chk("R9 write0 keeps", v & 32'd1, 32'd1);
        wr(3'd4, 32'd1);
        rd(3'd4, v);
        chk("R9 write1 clears", v & 32'd1, 32'd0);
        pulse_exit();

        finish_run();
    end

endmodule